// File: doc/BRIEF.md
# Select-Coded Clock Fan-Out Divider

This block divides one clock source and sends the result to five identical true/complement output pairs. A two-way source mux picks one of two reference clocks. A path input then chooses either that reference (the bypass path) or a separate external clock that stands in for a frequency synthesizer output. A 4-bit code sets the divide ratio. The code maps onto the powers of two from 1 to 64, and the mapping is neither monotonic nor one-to-one. A synchronous, active-high master reset clears the divider and parks every pair at true-low / complement-high.

All logic runs on one fast sampling clock `clk`. The source inputs are clock waveforms sampled by `clk`. A rising source edge is detected in the sampling domain and advances the divider. Even ratios toggle the divider output after every ratio/2 source rising edges, which gives a 50% duty cycle. Ratio 1 passes the sampled source level straight through. A new code is adopted only at the end of a full output period, so a change never cuts a pulse short.

Top module: `clk_fanout_div`

## Requirements
- R1: With `path_sel` = 0, `ref_pick` = 0 takes the source from `ref0_in` and `ref_pick` = 1 takes it from `ref1_in`; activity on the reference not picked has no effect on the outputs.
- R2: With `path_sel` = 1, the source is `ext_clk_in` and both reference inputs are ignored; with `path_sel` = 0, `ext_clk_in` is ignored.
- R3: With `path_sel` = 0, `div_code` sets the divide ratio as follows: 13 and 15 give 1; 10, 11 and 14 give 2; 0, 1, 2 and 12 give 4; 3, 4 and 5 give 8; 6 and 7 give 16; 8 gives 32; 9 gives 64.
- R4: With `path_sel` = 1, `div_code` sets the ratio as follows: 0 to 3 and 10 to 15 give 1; 4 to 6 give 2; 7 and 8 give 4; 9 gives 8.
- R5: All five true outputs always carry the same value.
- R6: Each `q_comp` bit is the exact inverse of the matching `q_true` bit at all times, including during reset.
- R7: One cycle after `rst` is seen high, every `q_true` bit is 0 and every `q_comp` bit is 1, and they stay there while `rst` is high.
- R8: For ratio N of 2 or more, the output period is N source periods and the high time is N/2 source periods. For ratio 1, the output follows the source level, with the same period and high time as the source.
- R9: After reset is released with the source low, the first output rising edge follows the (N/2)-th source rising edge for N of 2 or more, and follows the first source rising edge for N = 1.
- R10: A change of `div_code` while the output runs takes effect only at the end of the current output period, where the output falls; the pulse in progress keeps the old width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all logic |
| rst | input | 1 | Synchronous active-high master reset |
| ref0_in | input | 1 | Reference clock 0 waveform |
| ref1_in | input | 1 | Reference clock 1 waveform |
| ext_clk_in | input | 1 | External clock waveform (synthesizer stand-in) |
| ref_pick | input | 1 | 0 picks reference 0, 1 picks reference 1 |
| path_sel | input | 1 | 0 bypass path from picked reference, 1 external clock path |
| div_code | input | 4 | Divide ratio select code |
| q_true | output | 5 | True outputs of the five pairs |
| q_comp | output | 5 | Complement outputs of the five pairs |

## Verification
The hardest situation to create from the ports is a code change that lands in the middle of a running output period. In that case the old ratio must finish its high phase before the new ratio is adopted. The stimulus starts a divide-by-8 run and lets five source edges pass, so the output is part way through its high phase. It then switches to a divide-by-2 code and measures the width of that high pulse and the spacing of the rising edges that follow. The sweep also drives each source only on the path that should be blind to it, and checks that no output edge appears.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    localparam int SEL_W   = 4;
    localparam int NUM_OUT = 5;
    localparam int MAX_EXP = 6;
    localparam int EXP_W   = $clog2(MAX_EXP + 1);
    localparam int CNT_W   = (MAX_EXP > 1) ? MAX_EXP - 1 : 1;

    typedef enum logic {
        PATH_BYPASS = 1'b0,
        PATH_EXT    = 1'b1
    } path_e;

    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic level;
        logic rise;
    } src_ev_t;

    // ratio exponent for the bypass path
    function automatic exp_t bypass_exp(logic [SEL_W-1:0] c);
        exp_t e;
        case (c)
            4'd13, 4'd15:         e = exp_t'(0);
            4'd10, 4'd11, 4'd14:  e = exp_t'(1);
            4'd0, 4'd1, 4'd2,
            4'd12:                e = exp_t'(2);
            4'd3, 4'd4, 4'd5:     e = exp_t'(3);
            4'd6, 4'd7:           e = exp_t'(4);
            4'd8:                 e = exp_t'(5);
            default:              e = exp_t'(6);
        endcase
        return e;
    endfunction

    // ratio exponent for the external clock path
    function automatic exp_t ext_exp(logic [SEL_W-1:0] c);
        exp_t e;
        case (c)
            4'd4, 4'd5, 4'd6: e = exp_t'(1);
            4'd7, 4'd8:       e = exp_t'(2);
            4'd9:             e = exp_t'(3);
            default:          e = exp_t'(0);
        endcase
        return e;
    endfunction

    // last count value of a half period for a given exponent
    function automatic cnt_t half_last(exp_t e);
        int s;
        if (e == exp_t'(0)) return '0;
        s = int'(e) - 1;
        return cnt_t'((32'd1 << s) - 32'd1);
    endfunction

endpackage

// File: rtl/cfd_src_mux.sv
module cfd_src_mux
    import cfd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ref0_in,
    input  logic    ref1_in,
    input  logic    ext_in,
    input  logic    ref_pick,
    input  path_e   path,
    output src_ev_t ev
);

    logic ref_lvl;
    logic src_lvl;
    logic lvl_q;
    logic lvl_d;

    always_comb begin
        ref_lvl = ref_pick ? ref1_in : ref0_in;
        src_lvl = (path == PATH_EXT) ? ext_in : ref_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            lvl_d <= 1'b0;
        end else begin
            lvl_q <= src_lvl;
            lvl_d <= lvl_q;
        end
    end

    always_comb begin
        ev.level = lvl_q;
        ev.rise  = lvl_q & ~lvl_d;
    end

endmodule

// File: rtl/cfd_ratio_dec.sv
module cfd_ratio_dec
    import cfd_pkg::*;
(
    input  path_e            path,
    input  logic [SEL_W-1:0] code,
    output exp_t             exp_sel
);

    always_comb begin
        if (path == PATH_EXT) exp_sel = ext_exp(code);
        else                  exp_sel = bypass_exp(code);
    end

endmodule

// File: rtl/cfd_divider.sv
module cfd_divider
    import cfd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  src_ev_t ev,
    input  exp_t    pend_exp,
    output logic    div_out
);

    cnt_t cnt;
    exp_t cur_exp;
    logic y;
    logic at_last;
    logic wrap;

    always_comb begin
        at_last = (cnt == half_last(cur_exp));
        wrap    = ev.rise && at_last && y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            y       <= 1'b0;
            cur_exp <= pend_exp;
        end else if (cur_exp == exp_t'(0)) begin
            if (!ev.level) begin
                cur_exp <= pend_exp;
                cnt     <= '0;
                y       <= 1'b0;
            end else begin
                y <= 1'b1;
            end
        end else if (ev.rise) begin
            if (at_last) begin
                cnt <= '0;
                y   <= ~y;
                if (y) cur_exp <= pend_exp;
            end else begin
                cnt <= cnt + cnt_t'(1);
            end
        end
    end

    assign div_out = y;

    // R8: counter never passes the half-period limit
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (cur_exp != exp_t'(0)) |-> (cnt <= half_last(cur_exp)));

    // R8: an even-ratio output only moves on a source rising edge
    a_r8_toggle_on_edge: assert property (@(posedge clk) disable iff (rst)
        (cur_exp != exp_t'(0) && !ev.rise) |=> $stable(y));

    // R10: the active ratio changes only at the end of a period
    a_r10_hold_ratio: assert property (@(posedge clk) disable iff (rst)
        (cur_exp != exp_t'(0) && !wrap) |=> $stable(cur_exp));

endmodule

// File: rtl/cfd_fanout.sv
module cfd_fanout
    import cfd_pkg::*;
#(
    parameter int N_PAIR = NUM_OUT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_in,
    output logic [N_PAIR-1:0] q_t,
    output logic [N_PAIR-1:0] q_c
);

    for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
        logic t_r;
        logic c_r;
        always_ff @(posedge clk) begin
            if (rst) begin
                t_r <= 1'b0;
                c_r <= 1'b1;
            end else begin
                t_r <= div_in;
                c_r <= ~div_in;
            end
        end
        assign q_t[i] = t_r;
        assign q_c[i] = c_r;
    end

    logic armed;
    logic rst_d;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
        rst_d <= rst;
    end

    always @(negedge clk) begin
        if (armed) begin
            // R6: complement pairs stay inverse
            a_r6_comp_inverse: assert (q_c == ~q_t);
            // R5: all true outputs agree
            a_r5_same_outputs: assert (q_t == {N_PAIR{q_t[0]}});
            // R7: reset parks the pairs
            if (rst_d) begin
                a_r7_reset_levels: assert (q_t == '0 && q_c == '1);
            end
        end
    end

endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div
    import cfd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ref0_in,
    input  logic               ref1_in,
    input  logic               ext_clk_in,
    input  logic               ref_pick,
    input  logic               path_sel,
    input  logic [SEL_W-1:0]   div_code,
    output logic [NUM_OUT-1:0] q_true,
    output logic [NUM_OUT-1:0] q_comp
);

    path_e   path;
    src_ev_t ev;
    exp_t    pend_exp;
    logic    div_q;

    assign path = path_e'(path_sel);

    cfd_src_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .ref0_in  (ref0_in),
        .ref1_in  (ref1_in),
        .ext_in   (ext_clk_in),
        .ref_pick (ref_pick),
        .path     (path),
        .ev       (ev)
    );

    cfd_ratio_dec u_dec (
        .path    (path),
        .code    (div_code),
        .exp_sel (pend_exp)
    );

    cfd_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .pend_exp (pend_exp),
        .div_out  (div_q)
    );

    cfd_fanout #(.N_PAIR(NUM_OUT)) u_fan (
        .clk    (clk),
        .rst    (rst),
        .div_in (div_q),
        .q_t    (q_true),
        .q_c    (q_comp)
    );

endmodule

// File: tb/clk_fanout_div_tb.sv
module clk_fanout_div_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref0_in, ref1_in, ext_clk_in;
    logic       ref_pick, path_sel;
    logic [3:0] div_code;
    logic [4:0] q_true, q_comp;

    always #10 clk = ~clk;

    clk_fanout_div u_dut (
        .clk        (clk),
        .rst        (rst),
        .ref0_in    (ref0_in),
        .ref1_in    (ref1_in),
        .ext_clk_in (ext_clk_in),
        .ref_pick   (ref_pick),
        .path_sel   (path_sel),
        .div_code   (div_code),
        .q_true     (q_true),
        .q_comp     (q_comp)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int tick = 0;
    int n_rise, n_fall, bad_pair, first_src, src_edges;
    int rise_t [8];
    int fall_t [8];
    logic prev_q = 1'b0;

    always @(negedge clk) begin
        tick++;
        if (q_true !== {5{q_true[0]}} || q_comp !== ~q_true) bad_pair++;
        if (q_true[0] === 1'b1 && prev_q === 1'b0) begin
            if (n_rise < 8) rise_t[n_rise] = tick;
            if (n_rise == 0) first_src = src_edges;
            n_rise++;
        end
        if (q_true[0] === 1'b0 && prev_q === 1'b1 && n_rise > 0) begin
            if (n_fall < 8) fall_t[n_fall] = tick;
            n_fall++;
        end
        prev_q = q_true[0];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input int m, input int code);
        if (m == 0) begin
            case (code)
                13, 15:         return 1;
                10, 11, 14:     return 2;
                0, 1, 2, 12:    return 4;
                3, 4, 5:        return 8;
                6, 7:           return 16;
                8:              return 32;
                default:        return 64;
            endcase
        end
        case (code)
            4, 5, 6: return 2;
            7, 8:    return 4;
            9:       return 8;
            default: return 1;
        endcase
    endfunction

    task automatic set_src(input int which, input logic v);
        case (which)
            0: ref0_in = v;
            1: ref1_in = v;
            default: ext_clk_in = v;
        endcase
    endtask

    task automatic start(input int m, input int rs, input int code);
        @(negedge clk);
        rst = 1'b1;
        ref0_in = 1'b0; ref1_in = 1'b0; ext_clk_in = 1'b0;
        path_sel = m[0]; ref_pick = rs[0]; div_code = code[3:0];
        repeat (3) @(negedge clk);
        n_rise = 0; n_fall = 0; bad_pair = 0; first_src = -1; src_edges = 0;
        rst = 1'b0;
    endtask

    task automatic drive(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            set_src(which, 1'b1);
            src_edges++;
            repeat (3) @(negedge clk);
            @(negedge clk);
            set_src(which, 1'b0);
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic run_cfg(input int m, input int rs, input int code, input int which);
        int r;
        int ef;
        string rq;
        r  = exp_ratio(m, code);
        rq = (m == 0) ? "R3" : "R4";
        ef = (r < 2) ? 1 : r / 2;
        start(m, rs, code);
        drive(which, 3 * r + 2);
        repeat (4) @(negedge clk);
        chk(n_rise >= 3, "R8 rise count", n_rise, 3);
        if (n_rise >= 3) begin
            chk(rise_t[1] - rise_t[0] == 8 * r, rq, rise_t[1] - rise_t[0], 8 * r);
            chk(rise_t[2] - rise_t[1] == 8 * r, rq, rise_t[2] - rise_t[1], 8 * r);
            chk(fall_t[0] - rise_t[0] == 4 * r, "R8 high time", fall_t[0] - rise_t[0], 4 * r);
        end
        chk(first_src == ef, "R9 first rise", first_src, ef);
        chk(bad_pair == 0, "R5/R6 pairs", bad_pair, 0);
    endtask

    task automatic run_quiet(input int m, input int rs, input int code, input int which, input string rq);
        start(m, rs, code);
        drive(which, 20);
        repeat (4) @(negedge clk);
        chk(n_rise == 0, rq, n_rise, 0);
        chk(q_true == 5'h00, rq, q_true, 0);
    endtask

    initial begin
        rst = 1'b1;
        ref0_in = 1'b0; ref1_in = 1'b0; ext_clk_in = 1'b0;
        ref_pick = 1'b0; path_sel = 1'b1; div_code = 4'd0;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(q_true == 5'h00, "R7 reset true", q_true, 0);
        chk(q_comp == 5'h1F, "R7 reset comp", q_comp, 31);

        // R3 bypass sweep, R1 reference picked by code parity
        for (int c = 0; c < 16; c++) run_cfg(0, c % 2, c, c % 2);
        // R4 external path sweep, reference pick toggled (R2)
        for (int c = 0; c < 16; c++) run_cfg(1, c % 2, c, 2);

        // R1: reference not picked has no effect
        run_quiet(0, 0, 13, 1, "R1 ref1 ignored");
        run_quiet(0, 1, 13, 0, "R1 ref0 ignored");
        // R2: path isolation
        run_quiet(1, 0, 0, 0, "R2 ref ignored on ext path");
        run_quiet(0, 0, 13, 2, "R2 ext ignored on bypass");

        // R8 ratio 1 follows, then R7 reset mid-high
        start(0, 0, 13);
        @(negedge clk);
        ref0_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(q_true == 5'h1F, "R8 ratio1 follow", q_true, 31);
        rst = 1'b1;
        @(negedge clk);
        chk(q_true == 5'h00, "R7 reset true mid", q_true, 0);
        chk(q_comp == 5'h1F, "R7 reset comp mid", q_comp, 31);
        ref0_in = 1'b0;
        @(negedge clk); ref0_in = 1'b1;
        @(negedge clk); ref0_in = 1'b0;
        chk(q_true == 5'h00 && q_comp == 5'h1F, "R7 reset held", q_true, 0);

        // R10 code change mid high phase: /8 -> /2
        start(0, 0, 3);
        drive(0, 5);
        div_code = 4'd10;
        drive(0, 12);
        repeat (4) @(negedge clk);
        chk(n_rise >= 3, "R10 rise count", n_rise, 3);
        if (n_rise >= 3) begin
            chk(fall_t[0] - rise_t[0] == 32, "R10 pulse kept", fall_t[0] - rise_t[0], 32);
            chk(rise_t[1] - rise_t[0] == 40, "R10 wrap point", rise_t[1] - rise_t[0], 40);
            chk(rise_t[2] - rise_t[1] == 16, "R10 new ratio", rise_t[2] - rise_t[1], 16);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule